// File: doc/BRIEF.md
# Tuner Serial Control Receiver

This block is the two-wire serial target that loads the settings of a frequency synthesizer. A faster system clock samples the clock line (SCL) and the data line (SDA) through synchronizers. Edge detection on the synchronized lines finds start and stop conditions. The address byte has five fixed bits and two bits that must equal two strap inputs. The block acknowledges the address byte and every data byte it accepts by pulling SDA low during the ninth clock.

Writes carry no sub-address. The most significant bit of the first data byte, and of the third data byte when there is one, is a function bit. A 0 in that bit makes the byte and the byte after it a divider pair, which loads a 15-bit divide ratio. A 1 makes them a control pair, which loads the control fields and four band-select lines. A pair reaches the outputs only once both of its bytes have arrived.

A read returns one status byte. That byte holds a power-on flag, a lock flag and a 3-bit converter code.

Top module: `tuner_i2c_rx`

## Requirements
- R1: The target acknowledges an address byte equal to {1,1,0,0,0,selHi,selLo,rw}, sent MSB first, by holding `sdaOe` high through the ninth SCL high phase. rw=0 is a write and rw=1 is a read.
- R2: An address byte that does not match is not acknowledged. Every byte after it up to the next start condition is neither acknowledged nor applied to any output.
- R3: When a data byte with bit 7 = 0 starts a pair, the next byte completes it, and `divWord` becomes {first[6:0], second[7:0]}.
- R4: When a data byte with bit 7 = 1 starts a pair, the next byte completes it. Then `cpSel`=first[6], `testBits`=first[5:3], `refSel`=first[2:1] and `outOff`=first[0]. `bandLines` takes second[3:0] and ignores second[7:4]. `divWord` is left unchanged.
- R5: A four-byte write applies both pairs in either order, divider then control or control then divider. The third byte's bit 7 selects the type of the second pair.
- R6: A pair cut short by a stop or a repeated start changes no output. A pair that completed earlier in the same transfer still takes effect.
- R7: Each data byte of a matched write is acknowledged on its ninth clock.
- R8: A read returns {porFlag, lockIn, 0, 0, 0, convIn[2:0]} MSB first. The target changes SDA only while SCL is low.
- R9: The power-on flag reads 1 after reset. It reads 0 once a status byte has been clocked out and the controller's acknowledge bit has been sampled.
- R10: After the controller's not-acknowledge on a read, `sdaOe` stays low until the next start condition.
- R11: After reset `divWord`, every control field and `bandLines` are 0, and `sdaOe` is 0.
- R12: An SDA transition is taken as a start (falling) or a stop (rising) only while SCL is high. SDA changes while SCL is low are data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen at the pin |
| sdaIn | input | 1 | Serial data line as seen at the pin |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain drive) |
| selHi | input | 1 | Strap compared with address bit 2 |
| selLo | input | 1 | Strap compared with address bit 1 |
| lockIn | input | 1 | Lock indication reported in the status byte |
| convIn | input | 3 | Converter code reported in the status byte |
| divWord | output | 15 | Divide ratio |
| cpSel | output | 1 | Charge-pump current select |
| testBits | output | 3 | Test-mode bits |
| refSel | output | 2 | Reference divider select, {first[2], first[1]} |
| outOff | output | 1 | Tuning output disable |
| bandLines | output | 4 | Band-select lines |

## Verification
The assertions assume that the controller changes SDA only while SCL is low, except when it forms a start or a stop. They also assume that each SCL phase lasts well beyond the synchronizer delay, so that output updates and changes of `sdaOe` fall inside an SCL low phase. The stimulus meets both conditions. It holds every SCL phase for ten system clocks and moves SDA two clocks after each SCL fall. It forms starts and stops only while the target has released the line. That is why every read ends with a not-acknowledge before the stop.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;

  typedef struct packed {
    logic rxShift;
    logic wrByte;
    logic pairClear;
    logic txLoad;
    logic txShift;
    logic statusDone;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WBYTE,
    ST_ACKOUT,
    ST_RBYTE,
    ST_ACKIN,
    ST_SKIP
  } state_t;

endpackage

// File: rtl/tuner_i2c_sync.sv
module tuner_i2c_sync #(
  parameter int  STAGES    = 2,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= din;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/tuner_i2c_ctrl.sv
module tuner_i2c_ctrl
  import tuner_i2c_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclS,
  input  logic    sdaS,
  input  logic    addrMatch,
  input  logic    rwBit,
  input  logic    txBit,
  output strobe_t strb,
  output logic    sdaOe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic sclD, sdaD;
  state_t state, stateN;
  logic [CNT_W-1:0] bitCnt, cntN;
  logic readMode, readN;

  logic sclRise, sclFall, startCond, stopCond;
  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startCond = sclS & sclD & sdaD & ~sdaS;
  assign stopCond  = sclS & sclD & ~sdaD & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD     <= 1'b1;
      sdaD     <= 1'b1;
      state    <= ST_IDLE;
      bitCnt   <= '0;
      readMode <= 1'b0;
    end else begin
      sclD     <= sclS;
      sdaD     <= sdaS;
      state    <= stateN;
      bitCnt   <= cntN;
      readMode <= readN;
    end
  end

  always_comb begin
    stateN = state;
    cntN   = bitCnt;
    readN  = readMode;
    strb   = '0;
    if (startCond) begin
      stateN = ST_ADDR;
      cntN   = '0;
      strb.pairClear = 1'b1;
    end else if (stopCond) begin
      stateN = ST_IDLE;
      cntN   = '0;
      strb.pairClear = 1'b1;
    end else begin
      case (state)
        ST_ADDR, ST_WBYTE: begin
          if (sclRise && bitCnt < FULL) begin
            strb.rxShift = 1'b1;
            cntN = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL) begin
            cntN = '0;
            if (state == ST_ADDR) begin
              if (addrMatch) begin
                stateN = ST_ACKOUT;
                readN  = rwBit;
              end else begin
                stateN = ST_SKIP;
              end
            end else begin
              strb.wrByte = 1'b1;
              stateN = ST_ACKOUT;
            end
          end
        end
        ST_ACKOUT: begin
          if (sclFall) begin
            cntN = '0;
            if (readMode) begin
              stateN = ST_RBYTE;
              strb.txLoad = 1'b1;
            end else begin
              stateN = ST_WBYTE;
            end
          end
        end
        ST_RBYTE: begin
          if (sclFall) begin
            if (bitCnt == LAST) begin
              stateN = ST_ACKIN;
              cntN   = '0;
            end else begin
              strb.txShift = 1'b1;
              cntN = bitCnt + 1'b1;
            end
          end
        end
        ST_ACKIN: begin
          if (sclRise) begin
            strb.statusDone = 1'b1;
            if (sdaS) stateN = ST_SKIP;
            else cntN = CNT_W'(1);
          end else if (sclFall && bitCnt != '0) begin
            stateN = ST_RBYTE;
            cntN   = '0;
            strb.txLoad = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaOe = (state == ST_ACKOUT) | ((state == ST_RBYTE) & ~txBit);
endmodule

// File: rtl/tuner_i2c_dp.sv
module tuner_i2c_dp
  import tuner_i2c_pkg::*;
#(
  parameter int         DIV_W     = 15,
  parameter int         BAND_W    = 4,
  parameter int         CONV_W    = 3,
  parameter logic [4:0] ADDR_FIX  = 5'b11000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaS,
  input  strobe_t           strb,
  input  logic              selHi,
  input  logic              selLo,
  input  logic              lockIn,
  input  logic [CONV_W-1:0] convIn,
  output logic              addrMatch,
  output logic              rwBit,
  output logic              txBit,
  output logic [DIV_W-1:0]  divWord,
  output logic              cpSel,
  output logic [2:0]        testBits,
  output logic [1:0]        refSel,
  output logic              outOff,
  output logic [BAND_W-1:0] bandLines
);
  localparam int BYTE_W   = 8;
  localparam int DIV_HI_W = DIV_W - BYTE_W;
  localparam int FILL_W   = BYTE_W - 2 - CONV_W;

  logic [BYTE_W-1:0] rxReg, txReg;
  logic [BYTE_W-2:0] firstByte;
  logic              firstKind, havePair, porFlag;

  assign addrMatch = (rxReg[BYTE_W-1:1] == {ADDR_FIX, selHi, selLo});
  assign rwBit     = rxReg[0];
  assign txBit     = txReg[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg     <= '0;
      txReg     <= '0;
      firstByte <= '0;
      firstKind <= 1'b0;
      havePair  <= 1'b0;
      porFlag   <= 1'b1;
      divWord   <= '0;
      cpSel     <= 1'b0;
      testBits  <= '0;
      refSel    <= '0;
      outOff    <= 1'b0;
      bandLines <= '0;
    end else begin
      if (strb.rxShift) rxReg <= {rxReg[BYTE_W-2:0], sdaS};
      if (strb.pairClear) begin
        havePair <= 1'b0;
      end else if (strb.wrByte) begin
        if (!havePair) begin
          firstByte <= rxReg[BYTE_W-2:0];
          firstKind <= rxReg[BYTE_W-1];
          havePair  <= 1'b1;
        end else begin
          havePair <= 1'b0;
          if (firstKind) begin
            cpSel     <= firstByte[6];
            testBits  <= firstByte[5:3];
            refSel    <= firstByte[2:1];
            outOff    <= firstByte[0];
            bandLines <= rxReg[BAND_W-1:0];
          end else begin
            divWord <= {firstByte[DIV_HI_W-1:0], rxReg};
          end
        end
      end
      if (strb.txLoad) txReg <= {porFlag, lockIn, {FILL_W{1'b0}}, convIn};
      else if (strb.txShift) txReg <= {txReg[BYTE_W-2:0], 1'b0};
      if (strb.statusDone) porFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/tuner_i2c_rx.sv
module tuner_i2c_rx
  import tuner_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 15,
  parameter int BAND_W      = 4,
  parameter int CONV_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              selHi,
  input  logic              selLo,
  input  logic              lockIn,
  input  logic [CONV_W-1:0] convIn,
  output logic [DIV_W-1:0]  divWord,
  output logic              cpSel,
  output logic [2:0]        testBits,
  output logic [1:0]        refSel,
  output logic              outOff,
  output logic [BAND_W-1:0] bandLines
);
  logic    sclS, sdaS, addrMatch, rwBit, txBit;
  strobe_t strb;

  tuner_i2c_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sclSync_i (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS));
  tuner_i2c_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sdaSync_i (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS));

  tuner_i2c_ctrl #(.BYTE_W(8)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .addrMatch(addrMatch), .rwBit(rwBit), .txBit(txBit),
    .strb(strb), .sdaOe(sdaOe));

  tuner_i2c_dp #(.DIV_W(DIV_W), .BAND_W(BAND_W), .CONV_W(CONV_W)) dp_i (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .strb(strb),
    .selHi(selHi), .selLo(selLo), .lockIn(lockIn), .convIn(convIn),
    .addrMatch(addrMatch), .rwBit(rwBit), .txBit(txBit),
    .divWord(divWord), .cpSel(cpSel), .testBits(testBits), .refSel(refSel),
    .outOff(outOff), .bandLines(bandLines));
endmodule

// File: rtl/tuner_i2c_rx_chk.sv
module tuner_i2c_rx_chk #(
  parameter int DIV_W  = 15,
  parameter int BAND_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic [DIV_W-1:0]  divWord,
  input logic              cpSel,
  input logic [2:0]        testBits,
  input logic [1:0]        refSel,
  input logic              outOff,
  input logic [BAND_W-1:0] bandLines
);
  logic [6:0] ctrlFields;
  assign ctrlFields = {cpSel, testBits, refSel, outOff};

  assert_ack_low_phase_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);

  assert_release_low_phase_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> !sclIn);

  assert_div_alone_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divWord) |-> ($stable(ctrlFields) && $stable(bandLines)));

  assert_div_in_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divWord) |-> !sclIn);

  assert_ctrl_in_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(ctrlFields) || !$stable(bandLines)) |-> !sclIn);
endmodule

bind tuner_i2c_rx tuner_i2c_rx_chk #(.DIV_W(DIV_W), .BAND_W(BAND_W)) chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .divWord(divWord),
  .cpSel(cpSel), .testBits(testBits), .refSel(refSel), .outOff(outOff),
  .bandLines(bandLines));

// File: tb/tuner_i2c_rx_tb_top.sv
`timescale 1ns/1ps
module tuner_i2c_rx_tb_top;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic selHi = 1'b0, selLo = 1'b0, lockIn = 1'b0;
  logic [2:0] convIn = '0;
  logic sdaOe, cpSel, outOff, sdaBus;
  logic [14:0] divWord;
  logic [2:0] testBits;
  logic [1:0] refSel;
  logic [3:0] bandLines;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  logic [14:0] expDiv;
  logic [6:0]  expCtrl;
  logic [3:0]  expBand;
  logic        expPor;

  always #2 clk = ~clk;
  assign sdaBus = sdaM & ~sdaOe;

  tuner_i2c_rx dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .selHi(selHi), .selLo(selLo), .lockIn(lockIn), .convIn(convIn),
    .divWord(divWord), .cpSel(cpSel), .testBits(testBits), .refSel(refSel),
    .outOff(outOff), .bandLines(bandLines));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(H);
    sclM = 1'b1; tick(H);
    sdaM = 1'b0; tick(H);
    sclM = 1'b0; tick(2);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(H);
    sclM = 1'b1; tick(H);
    sdaM = 1'b1; tick(H);
  endtask

  task automatic clockBit(input logic b, output logic seen);
    sdaM = b; tick(H);
    sclM = 1'b1; tick(H/2);
    seen = sdaBus; tick(H/2);
    sclM = 1'b0; tick(2);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(v[i], s);
    clockBit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recvByte(output logic [7:0] v, input logic ackBit);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      v[i] = s;
    end
    clockBit(ackBit, s);
    sdaM = 1'b1;
  endtask

  // Sends start, address and n bytes from d (first byte in d[31:24]), then stop.
  task automatic writeTxn(input logic [7:0] addr, input int n, input logic [31:0] d,
                          output logic addrAck, output int dataAcks);
    logic a;
    busStart();
    sendByte(addr, addrAck);
    dataAcks = 0;
    for (int i = 0; i < n; i++) begin
      sendByte(d[31-8*i -: 8], a);
      if (a) dataAcks++;
    end
    busStop();
  endtask

  task automatic readTxn(input logic [7:0] addr, output logic addrAck, output logic [7:0] v);
    busStart();
    sendByte(addr, addrAck);
    recvByte(v, 1'b1);
    tick(3);
    check(sdaOe == 1'b0, "R10 released after nack", sdaOe, 0);
    busStop();
  endtask

  task automatic checkOutputs(input string req);
    check(divWord == expDiv, req, divWord, expDiv);
    check({cpSel, testBits, refSel, outOff} == expCtrl, req, {cpSel, testBits, refSel, outOff}, expCtrl);
    check(bandLines == expBand, req, bandLines, expBand);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic ack;
    int nAck;
    logic [7:0] rd;
    logic [7:0] addrW, addrR;
    tick(5);
    rstN = 1'b1;
    tick(5);
    expDiv = '0; expCtrl = '0; expBand = '0; expPor = 1'b1;

    // R11 reset state
    checkOutputs("R11 reset outputs");
    check(sdaOe == 1'b0, "R11 sdaOe after reset", sdaOe, 0);

    // R1 R2 R3 R7: address sweep over all strap and address combinations
    for (int sel = 0; sel < 4; sel++) begin
      for (int ma = 0; ma < 4; ma++) begin
        logic [14:0] val;
        bit match;
        {selHi, selLo} = 2'(sel);
        val = 15'(((sel * 4 + ma) * 2053 + 1) & 32'h7fff);
        match = (sel == ma);
        writeTxn({5'b11000, 2'(ma), 1'b0}, 2, {1'b0, val[14:8], val[7:0], 16'h0}, ack, nAck);
        tick(4);
        check(ack == match, match ? "R1 address ack" : "R2 address no ack", ack, match);
        check(nAck == (match ? 2 : 0), match ? "R7 data acks" : "R2 data ignored", nAck, match ? 2 : 0);
        if (match) expDiv = val;
        check(divWord == expDiv, "R3 R2 divider after sweep", divWord, expDiv);
      end
    end

    selHi = 1'b1; selLo = 1'b0;
    addrW = 8'hC4; addrR = 8'hC5;

    // R3 R12: divider values including all-zero and all-one patterns
    for (int i = 0; i < 16; i++) begin
      logic [14:0] val;
      val = (i == 0) ? 15'h0 : (i == 15) ? 15'h7fff : 15'((i * 32'h1357) & 32'h7fff);
      writeTxn(addrW, 2, {1'b0, val[14:8], val[7:0], 16'h0}, ack, nAck);
      tick(4);
      expDiv = val;
      check(divWord == expDiv, "R3 R12 divider value", divWord, expDiv);
      check(nAck == 2, "R7 divider acks", nAck, 2);
    end

    // R4: control and band sweep
    for (int i = 0; i < 32; i++) begin
      logic [7:0] cb, bb;
      cb = 8'h80 | 8'((i * 37) & 127);
      bb = 8'((i * 53) & 255);
      writeTxn(addrW, 2, {cb, bb, 16'h0}, ack, nAck);
      tick(4);
      expCtrl = cb[6:0];
      expBand = bb[3:0];
      checkOutputs("R4 control pair");
    end

    // R5: four-byte writes in both orders
    writeTxn(addrW, 4, {8'h2A, 8'h5C, 8'hB3, 8'hF6}, ack, nAck);
    tick(4);
    expDiv = 15'h2A5C; expCtrl = 7'h33; expBand = 4'h6;
    checkOutputs("R5 divider then control");
    check(nAck == 4, "R5 R7 four acks", nAck, 4);
    writeTxn(addrW, 4, {8'hCE, 8'h09, 8'h11, 8'h77}, ack, nAck);
    tick(4);
    expDiv = 15'h1177; expCtrl = 7'h4E; expBand = 4'h9;
    checkOutputs("R5 control then divider");

    // R6: pair cut short by stop
    writeTxn(addrW, 1, {8'h3F, 24'h0}, ack, nAck);
    tick(4);
    checkOutputs("R6 half divider pair at stop");
    // R6: control pair completes, divider half then repeated start
    busStart();
    sendByte(addrW, ack);
    sendByte(8'hA5, ack);
    sendByte(8'h0C, ack);
    sendByte(8'h01, ack);
    busStart();
    sendByte(addrW, ack);
    sendByte(8'hFF, ack);
    busStop();
    tick(4);
    expCtrl = 7'h25; expBand = 4'hC;
    checkOutputs("R6 repeated start discards half pair");

    // R8 R9: status reads
    for (int l = 0; l < 2; l++) begin
      for (int c = 0; c < 8; c++) begin
        logic [7:0] expRd;
        lockIn = 1'(l);
        convIn = 3'(c);
        readTxn(addrR, ack, rd);
        expRd = {expPor, 1'(l), 3'b000, 3'(c)};
        check(ack == 1'b1, "R1 read address ack", ack, 1);
        check(rd == expRd, expPor ? "R9 R8 status with por" : "R8 status byte", rd, expRd);
        expPor = 1'b0;
      end
    end

    // R2: read with wrong address gets no ack and no drive
    readTxn(8'hC7, ack, rd);
    check(ack == 1'b0, "R2 read wrong address", ack, 0);
    check(rd == 8'hFF, "R2 no data driven", rd, 8'hFF);

    // R9 R11: reset again restores por and clears outputs
    rstN = 1'b0; tick(3); rstN = 1'b1; tick(5);
    expDiv = '0; expCtrl = '0; expBand = '0; expPor = 1'b1;
    checkOutputs("R11 second reset");
    lockIn = 1'b0; convIn = 3'd2;
    readTxn(addrR, ack, rd);
    check(rd == 8'h82, "R9 por after reset", rd, 8'h82);
    readTxn(addrR, ack, rd);
    check(rd == 8'h02, "R9 por cleared", rd, 8'h02);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule